// File: doc/BRIEF.md
# Pointer-Selected Register File with Context Switching

This block is the scratch register store of a small accumulator processor. It holds sixteen 16-bit entries. Each entry can also be reached as two bytes, which gives thirty-two byte registers. Two 4-bit selectors choose the entries with special roles. The program selector (`p_sel`) names the entry that acts as program counter. The index selector (`x_sel`) names the entry used as the pointer for implied memory operands.

Each cycle the instruction sequencer issues at most one command on a single-cycle command port:

- A fetch drives the program-counter entry onto `addr_out` and bumps that entry by one on the same edge. An operand read through the program counter therefore behaves as immediate addressing.
- Increment and decrement act on a whole entry.
- Every other change to an entry goes through a byte write to one half.

There is no call stack. Subroutines and coroutines run by loading the program selector with another entry number. An interrupt saves both selectors in an 8-bit context register (`t_reg`) and forces the program selector to entry 1. A return command restores both selectors from that context register.

Each cycle the decoder turns the command into one update kind: none, increment, decrement, write low byte or write high byte. It also picks one selector action: hold, load P, load X, interrupt save or restore. An interrupt request overrides the command in the decoder and is always served first.

Top module: `ptrsel_regfile`

## Requirements
- R1: While `rst_n` is low, and after it, `p_sel`, `x_sel` and `t_reg` read zero until a command changes them. Entry contents are undefined after reset.
- R2: `cmd_op`=4 writes `cmd_data` into one half of the entry `cmd_reg`: the low byte (bits 7:0) when `cmd_half`=0, the high byte (bits 15:8) when it is 1. The other half keeps its value. `rd_byte` shows, without a clock, half `rd_half` (same encoding) of entry `rd_sel`.
- R3: `cmd_op`=2 adds one to entry `cmd_reg` and `cmd_op`=3 subtracts one. Both act on all 16 bits and wrap modulo 65536.
- R4: With `cmd_op`=1 (fetch), `addr_out` equals the entry named by `p_sel` in that cycle. After the clock edge that entry holds that value plus one, modulo 65536.
- R5: With `cmd_op`=8, `addr_out` equals entry `cmd_reg`. With `cmd_op`=9, `addr_out` equals the entry named by `x_sel`. Neither command changes any entry.
- R6: `cmd_op`=5 loads `p_sel` from `cmd_reg` and leaves `x_sel` unchanged. `cmd_op`=6 loads `x_sel` from `cmd_reg` and leaves `p_sel` unchanged.
- R7: When `irq` is high, at the clock edge `t_reg` takes `x_sel` in bits 7:4 and `p_sel` in bits 3:0. `p_sel` becomes 1 and `x_sel` keeps its value. Any command in the same cycle is dropped.
- R8: `cmd_op`=7 (return) loads `x_sel` from `t_reg[7:4]` and `p_sel` from `t_reg[3:0]`. `t_reg` keeps its value.
- R9: `t_reg` changes only on an interrupt.
- R10: `cmd_op`=0 and codes 10 to 15 change no selector, no context bit and no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the selectors and context |
| cmd_op | input | 4 | Command code for this cycle |
| cmd_reg | input | 4 | Entry number or new selector value for the command |
| cmd_half | input | 1 | Byte half for a byte write (0 low, 1 high) |
| cmd_data | input | 8 | Byte to write |
| irq | input | 1 | Interrupt request; takes priority over the command |
| rd_sel | input | 4 | Entry for the byte read port |
| rd_half | input | 1 | Half for the byte read port (0 low, 1 high) |
| rd_byte | output | 8 | Selected byte |
| addr_out | output | 16 | Memory address for the current command |
| p_sel | output | 4 | Program-counter selector |
| x_sel | output | 4 | Index selector |
| t_reg | output | 8 | Saved selector pair {X, P} |

## Verification
The bench builds the block with its default parameters: sixteen entries of 16 bits and interrupt entry 1. At that size the bench can sweep every entry through both byte halves, increment, decrement and fetch. It also runs all 256 combinations of the index and program selectors through an interrupt and a return. Wrap-around is driven at 0xFFFF and 0x0000. An interrupt is raised in the same cycle as a selector load and as a byte write, to show the command is dropped. The unused command codes are swept with live operands.

// File: rtl/ptrsel_pkg.sv
package ptrsel_pkg;

    // Command codes seen on cmd_op
    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_FETCH    = 4'd1,
        OP_INC      = 4'd2,
        OP_DEC      = 4'd3,
        OP_WRBYTE   = 4'd4,
        OP_SETP     = 4'd5,
        OP_SETX     = 4'd6,
        OP_RET      = 4'd7,
        OP_ADDR_REG = 4'd8,
        OP_ADDR_X   = 4'd9
    } op_e;

    // What happens to one entry this cycle
    typedef enum logic [2:0] {
        UPD_NONE,
        UPD_INC,
        UPD_DEC,
        UPD_LO,
        UPD_HI
    } upd_e;

    // What happens to the selector pair and context this cycle
    typedef enum logic [2:0] {
        CTX_HOLD,
        CTX_SETP,
        CTX_SETX,
        CTX_IRQ,
        CTX_RET
    } ctx_e;

    // Which entry drives the address output
    typedef enum logic [1:0] {
        AS_PC,
        AS_NAMED,
        AS_INDEX
    } addr_src_e;

endpackage

// File: rtl/ptrsel_decode.sv
module ptrsel_decode
    import ptrsel_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic [3:0]       cmd_op,
    input  logic             irq,
    input  logic             cmd_half,
    input  logic [SEL_W-1:0] cmd_reg,
    input  logic [SEL_W-1:0] p_sel,
    input  logic [SEL_W-1:0] x_sel,
    output upd_e             upd_kind,
    output logic [SEL_W-1:0] upd_idx,
    output ctx_e             ctx_act,
    output logic [SEL_W-1:0] addr_idx
);

    op_e       op;
    addr_src_e addr_src;

    assign op = op_e'(cmd_op);

    // Command to update kind and selector action; interrupt wins
    always_comb begin
        upd_kind = UPD_NONE;
        upd_idx  = cmd_reg;
        ctx_act  = CTX_HOLD;
        addr_src = AS_PC;
        if (irq) begin
            ctx_act = CTX_IRQ;
        end else begin
            unique case (op)
                OP_FETCH: begin
                    upd_kind = UPD_INC;
                    upd_idx  = p_sel;
                    addr_src = AS_PC;
                end
                OP_INC:      upd_kind = UPD_INC;
                OP_DEC:      upd_kind = UPD_DEC;
                OP_WRBYTE:   upd_kind = cmd_half ? UPD_HI : UPD_LO;
                OP_SETP:     ctx_act  = CTX_SETP;
                OP_SETX:     ctx_act  = CTX_SETX;
                OP_RET:      ctx_act  = CTX_RET;
                OP_ADDR_REG: addr_src = AS_NAMED;
                OP_ADDR_X:   addr_src = AS_INDEX;
                default: begin
                    upd_kind = UPD_NONE;
                    ctx_act  = CTX_HOLD;
                end
            endcase
        end
    end

    // Address entry choice
    always_comb begin
        unique case (addr_src)
            AS_NAMED: addr_idx = cmd_reg;
            AS_INDEX: addr_idx = x_sel;
            default:  addr_idx = p_sel;
        endcase
    end

endmodule

// File: rtl/ptrsel_ctx.sv
module ptrsel_ctx
    import ptrsel_pkg::*;
#(
    parameter int SEL_W  = 4,
    parameter int IRQ_PC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ctx_e               ctx_act,
    input  logic [SEL_W-1:0]   new_sel,
    output logic [SEL_W-1:0]   p_q,
    output logic [SEL_W-1:0]   x_q,
    output logic [2*SEL_W-1:0] t_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
            x_q <= '0;
            t_q <= '0;
        end else begin
            unique case (ctx_act)
                CTX_SETP: p_q <= new_sel;
                CTX_SETX: x_q <= new_sel;
                CTX_IRQ: begin
                    t_q <= {x_q, p_q};
                    p_q <= SEL_W'(IRQ_PC);
                end
                CTX_RET: begin
                    x_q <= t_q[2*SEL_W-1:SEL_W];
                    p_q <= t_q[SEL_W-1:0];
                end
                default: begin
                    p_q <= p_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/ptrsel_bank.sv
module ptrsel_bank
    import ptrsel_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int DATA_W  = 16,
    parameter int SEL_W   = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  upd_e                upd_kind,
    input  logic [SEL_W-1:0]    upd_idx,
    input  logic [DATA_W/2-1:0] upd_byte,
    output logic [DATA_W-1:0]   ent_q [ENTRIES]
);

    localparam int HALF_W = DATA_W / 2;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic hit;
        assign hit = (upd_idx == SEL_W'(g));

        always_ff @(posedge clk) begin
            if (hit) begin
                case (upd_kind)
                    UPD_INC: ent_q[g] <= ent_q[g] + DATA_W'(1);
                    UPD_DEC: ent_q[g] <= ent_q[g] - DATA_W'(1);
                    UPD_LO:  ent_q[g][HALF_W-1:0] <= upd_byte;
                    UPD_HI:  ent_q[g][DATA_W-1:HALF_W] <= upd_byte;
                    default: ent_q[g] <= ent_q[g];
                endcase
            end
        end
    end

endmodule

// File: rtl/ptrsel_view.sv
module ptrsel_view #(
    parameter int ENTRIES = 16,
    parameter int DATA_W  = 16,
    parameter int SEL_W   = $clog2(ENTRIES)
) (
    input  logic [DATA_W-1:0]   ent_q [ENTRIES],
    input  logic [SEL_W-1:0]    addr_idx,
    input  logic [SEL_W-1:0]    rd_sel,
    input  logic                rd_half,
    output logic [DATA_W-1:0]   addr_out,
    output logic [DATA_W/2-1:0] rd_byte
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] rd_word;

    assign addr_out = ent_q[addr_idx];
    assign rd_word  = ent_q[rd_sel];
    assign rd_byte  = rd_half ? rd_word[DATA_W-1:HALF_W] : rd_word[HALF_W-1:0];

endmodule

// File: rtl/ptrsel_regfile.sv
module ptrsel_regfile
    import ptrsel_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int DATA_W  = 16,
    parameter int IRQ_PC  = 1,
    parameter int SEL_W   = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          cmd_op,
    input  logic [SEL_W-1:0]    cmd_reg,
    input  logic                cmd_half,
    input  logic [DATA_W/2-1:0] cmd_data,
    input  logic                irq,
    input  logic [SEL_W-1:0]    rd_sel,
    input  logic                rd_half,
    output logic [DATA_W/2-1:0] rd_byte,
    output logic [DATA_W-1:0]   addr_out,
    output logic [SEL_W-1:0]    p_sel,
    output logic [SEL_W-1:0]    x_sel,
    output logic [2*SEL_W-1:0]  t_reg
);

    upd_e             upd_kind;
    ctx_e             ctx_act;
    logic [SEL_W-1:0] upd_idx;
    logic [SEL_W-1:0] addr_idx;
    logic [DATA_W-1:0] ent_q [ENTRIES];

    ptrsel_decode #(.SEL_W(SEL_W)) u_dec (
        .cmd_op   (cmd_op),
        .irq      (irq),
        .cmd_half (cmd_half),
        .cmd_reg  (cmd_reg),
        .p_sel    (p_sel),
        .x_sel    (x_sel),
        .upd_kind (upd_kind),
        .upd_idx  (upd_idx),
        .ctx_act  (ctx_act),
        .addr_idx (addr_idx)
    );

    ptrsel_ctx #(.SEL_W(SEL_W), .IRQ_PC(IRQ_PC)) u_ctx (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctx_act (ctx_act),
        .new_sel (cmd_reg),
        .p_q     (p_sel),
        .x_q     (x_sel),
        .t_q     (t_reg)
    );

    ptrsel_bank #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_bank (
        .clk      (clk),
        .upd_kind (upd_kind),
        .upd_idx  (upd_idx),
        .upd_byte (cmd_data),
        .ent_q    (ent_q)
    );

    ptrsel_view #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_view (
        .ent_q    (ent_q),
        .addr_idx (addr_idx),
        .rd_sel   (rd_sel),
        .rd_half  (rd_half),
        .addr_out (addr_out),
        .rd_byte  (rd_byte)
    );

endmodule

// File: rtl/ptrsel_regfile_chk.sv
module ptrsel_regfile_chk #(
    parameter int ENTRIES = 16,
    parameter int DATA_W  = 16,
    parameter int IRQ_PC  = 1,
    parameter int SEL_W   = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [3:0]         cmd_op,
    input logic [SEL_W-1:0]   cmd_reg,
    input logic               irq,
    input logic [DATA_W-1:0]  addr_out,
    input logic [SEL_W-1:0]   p_sel,
    input logic [SEL_W-1:0]   x_sel,
    input logic [2*SEL_W-1:0] t_reg,
    input logic [DATA_W-1:0]  ent_q [ENTRIES]
);

    // R4: fetched entry holds the issued address plus one
    a_r4_fetch_postinc: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 4'd1 && !irq) |=> ent_q[$past(p_sel)] == $past(addr_out) + DATA_W'(1));

    // R6: program selector load leaves the index selector alone
    a_r6_setp_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 4'd5 && !irq) |=> (p_sel == $past(cmd_reg)) && $stable(x_sel));

    // R7: interrupt saves {X,P} and vectors P
    a_r7_irq_save: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> (t_reg == {$past(x_sel), $past(p_sel)}) && (p_sel == SEL_W'(IRQ_PC))
                && $stable(x_sel));

    // R8: return restores both selectors from the context
    a_r8_return: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 4'd7 && !irq) |=> ({x_sel, p_sel} == $past(t_reg)) && $stable(t_reg));

    // R9: context moves only on an interrupt
    a_r9_ctx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |=> $stable(t_reg));

endmodule

bind ptrsel_regfile ptrsel_regfile_chk #(
    .ENTRIES(ENTRIES), .DATA_W(DATA_W), .IRQ_PC(IRQ_PC), .SEL_W(SEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_op   (cmd_op),
    .cmd_reg  (cmd_reg),
    .irq      (irq),
    .addr_out (addr_out),
    .p_sel    (p_sel),
    .x_sel    (x_sel),
    .t_reg    (t_reg),
    .ent_q    (ent_q)
);

// File: tb/ptrsel_regfile_test.sv
module ptrsel_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  cmd_op, cmd_reg, rd_sel;
    logic        cmd_half, irq, rd_half;
    logic [7:0]  cmd_data, rd_byte;
    logic [15:0] addr_out;
    logic [3:0]  p_sel, x_sel;
    logic [7:0]  t_reg;

    int          n_chk = 0, n_bad = 0;
    bit          done  = 1'b0;
    logic [15:0] mdl [16];
    logic [3:0]  mp, mx;
    logic [7:0]  mt;
    logic [15:0] addr_snap, word;

    always #5 clk = ~clk;

    ptrsel_regfile uut (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_reg(cmd_reg),
        .cmd_half(cmd_half), .cmd_data(cmd_data), .irq(irq),
        .rd_sel(rd_sel), .rd_half(rd_half), .rd_byte(rd_byte),
        .addr_out(addr_out), .p_sel(p_sel), .x_sel(x_sel), .t_reg(t_reg)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic cmd(input logic [3:0] op, input logic [3:0] r, input logic h,
                       input logic [7:0] d, input logic i);
        cmd_op = op; cmd_reg = r; cmd_half = h; cmd_data = d; irq = i;
        #2 addr_snap = addr_out;
        @(negedge clk);
        cmd_op = 4'd0; irq = 1'b0;
    endtask

    task automatic rd16(input logic [3:0] idx, output logic [15:0] v);
        rd_sel = idx; rd_half = 1'b0;
        #1 v[7:0] = rd_byte;
        rd_half = 1'b1;
        #1 v[15:8] = rd_byte;
        @(negedge clk);
    endtask

    task automatic ptrs(input string req);
        chk(req, {28'd0, p_sel}, {28'd0, mp});
        chk(req, {28'd0, x_sel}, {28'd0, mx});
        chk(req, {24'd0, t_reg}, {24'd0, mt});
    endtask

    initial begin
        rst_n = 1'b0; cmd_op = 0; cmd_reg = 0; cmd_half = 0; cmd_data = 0;
        irq = 0; rd_sel = 0; rd_half = 0;
        mp = 0; mx = 0; mt = 0;
        repeat (3) @(negedge clk);
        ptrs("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        ptrs("R1 after release");

        // R2: fill every entry byte by byte, read both halves
        for (int i = 0; i < 16; i++) begin
            mdl[i] = {8'(i * 7 + 8'hA0), 8'(i * 29 + 5)};
            cmd(4'd4, 4'(i), 1'b0, mdl[i][7:0], 1'b0);
            cmd(4'd4, 4'(i), 1'b1, mdl[i][15:8], 1'b0);
        end
        for (int i = 0; i < 16; i++) begin
            rd16(4'(i), word);
            chk("R2 fill", {16'd0, word}, {16'd0, mdl[i]});
        end
        for (int i = 0; i < 16; i++) begin
            mdl[i][15:8] = 8'(8'h3C ^ i);
            cmd(4'd4, 4'(i), 1'b1, mdl[i][15:8], 1'b0);
            rd16(4'(i), word);
            chk("R2 high only", {16'd0, word}, {16'd0, mdl[i]});
            mdl[i][7:0] = 8'(8'hC3 + i);
            cmd(4'd4, 4'(i), 1'b0, mdl[i][7:0], 1'b0);
            rd16(4'(i), word);
            chk("R2 low only", {16'd0, word}, {16'd0, mdl[i]});
        end

        // R3: wrap at both ends, then inc/dec sweep
        cmd(4'd4, 4'd2, 1'b0, 8'hFF, 1'b0);
        cmd(4'd4, 4'd2, 1'b1, 8'hFF, 1'b0);
        cmd(4'd2, 4'd2, 1'b0, 8'h00, 1'b0);
        rd16(4'd2, word);
        chk("R3 inc wrap", {16'd0, word}, 32'h0000);
        cmd(4'd3, 4'd2, 1'b0, 8'h00, 1'b0);
        rd16(4'd2, word);
        chk("R3 dec wrap", {16'd0, word}, 32'hFFFF);
        mdl[2] = 16'hFFFF;
        cmd(4'd4, 4'd6, 1'b0, 8'hFF, 1'b0);
        mdl[6][7:0] = 8'hFF;
        cmd(4'd2, 4'd6, 1'b0, 8'h00, 1'b0);
        mdl[6] = mdl[6] + 16'd1;
        rd16(4'd6, word);
        chk("R3 byte carry", {16'd0, word}, {16'd0, mdl[6]});
        for (int i = 0; i < 16; i++) begin
            cmd(4'd2, 4'(i), 1'b0, 8'h00, 1'b0);
            cmd(4'd2, 4'(i), 1'b0, 8'h00, 1'b0);
            cmd(4'd3, 4'(i), 1'b0, 8'h00, 1'b0);
            mdl[i] = mdl[i] + 16'd1;
            rd16(4'(i), word);
            chk("R3 sweep", {16'd0, word}, {16'd0, mdl[i]});
        end

        // R4: fetch through every program selector
        for (int i = 0; i < 16; i++) begin
            cmd(4'd5, 4'(i), 1'b0, 8'h00, 1'b0);
            mp = 4'(i);
            cmd(4'd1, 4'(15 - i), 1'b0, 8'h00, 1'b0);
            chk("R4 addr", {16'd0, addr_snap}, {16'd0, mdl[i]});
            mdl[i] = mdl[i] + 16'd1;
            cmd(4'd1, 4'(15 - i), 1'b0, 8'h00, 1'b0);
            chk("R4 addr second", {16'd0, addr_snap}, {16'd0, mdl[i]});
            mdl[i] = mdl[i] + 16'd1;
            rd16(4'(i), word);
            chk("R4 postinc", {16'd0, word}, {16'd0, mdl[i]});
        end

        // R5: named and index-relative addressing, no entry change
        for (int i = 0; i < 16; i++) begin
            cmd(4'd8, 4'(i), 1'b0, 8'h00, 1'b0);
            chk("R5 named", {16'd0, addr_snap}, {16'd0, mdl[i]});
            cmd(4'd6, 4'(i), 1'b0, 8'h00, 1'b0);
            mx = 4'(i);
            cmd(4'd9, 4'(15 - i), 1'b0, 8'h00, 1'b0);
            chk("R5 index", {16'd0, addr_snap}, {16'd0, mdl[i]});
            rd16(4'(i), word);
            chk("R5 unchanged", {16'd0, word}, {16'd0, mdl[i]});
        end

        // R6: selector loads
        cmd(4'd5, 4'd11, 1'b0, 8'h00, 1'b0); mp = 4'd11;
        ptrs("R6 setp");
        cmd(4'd6, 4'd4, 1'b0, 8'h00, 1'b0);  mx = 4'd4;
        ptrs("R6 setx");

        // R7 R8 R9: every selector pair through interrupt and return
        for (int x = 0; x < 16; x++) begin
            for (int p = 0; p < 16; p++) begin
                cmd(4'd6, 4'(x), 1'b0, 8'h00, 1'b0);
                cmd(4'd5, 4'(p), 1'b0, 8'h00, 1'b0);
                mx = 4'(x); mp = 4'(p);
                ptrs("R9 loads keep context");
                cmd(4'd5, 4'd9, 1'b0, 8'h00, 1'b1);
                mt = {mx, mp}; mp = 4'd1;
                ptrs("R7 interrupt");
                cmd(4'd7, 4'd0, 1'b0, 8'h00, 1'b0);
                mx = mt[7:4]; mp = mt[3:0];
                ptrs("R8 return");
            end
        end

        // R7: byte write in the interrupt cycle is dropped
        cmd(4'd4, 4'd3, 1'b1, ~mdl[3][15:8], 1'b1);
        mt = {mx, mp}; mp = 4'd1;
        rd16(4'd3, word);
        chk("R7 write dropped", {16'd0, word}, {16'd0, mdl[3]});
        ptrs("R7 second save");

        // R10: unused codes and no-op change nothing
        for (int c = 10; c < 17; c++) begin
            cmd(4'(c), 4'd3, 1'b1, 8'h5A, 1'b0);
            ptrs("R10 unused code");
            rd16(4'd3, word);
            chk("R10 entry kept", {16'd0, word}, {16'd0, mdl[3]});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule